// File: doc/BRIEF.md
# Embedded-Operation Status Register

This block keeps the 16-bit status word of a flash-style device. It watches event strobes from the embedded program and erase engine: start of an operation, completion with a pass or fail flag, a write-buffer abort, a rejection because the sector was locked, and acknowledgement that a suspend has taken effect. From this it keeps a ready flag, suspend flags and sticky error flags, and it presents them on a single status word that host reads return.

Host commands arrive as one-cycle strobes. A clear-status strobe and a soft-reset strobe remove the error flags. An erase or program suspend strobe arms a suspend request. An erase or program resume strobe restarts the suspended operation. A synchronous cold reset and a warm reset both restore the idle word. While an erase is suspended, a program aimed at the suspended sector is forced to report failure, whatever the engine says.

Top module: `eos_status_reg`

## Requirements
- R1: After cold reset the status word is 0x0080. Bit 7 is ready, bit 6 is erase-suspended, bit 5 is erase-failed, bit 4 is program-failed, bit 3 is write-buffer-abort, bit 2 is program-suspended and bit 1 is sector-locked. `op_kind_i` is 0 for program and 1 for erase.
- R2: Bits 15 to 8 and bit 0 always read 0.
- R3: While bit 7 is 0, bits 6 to 1 read 0.
- R4: An accepted `op_start_i` (taken only when bit 7 is 1) clears bit 7 on the next cycle. `op_done_i` while bit 7 is 0 sets bit 7 and, on the same cycle, writes the result flags of the operation. `op_done_i` while bit 7 is 1 has no effect.
- R5: `warm_rst_i` returns the word to 0x0080 on the next cycle.
- R6: `cmd_clear_i` or `cmd_reset_i` clears bits 5, 4, 3 and 1. Bits 6 and 2 are left unchanged.
- R7: When bit 7 is 1, erase resume clears bit 6 and program resume clears bit 2. Either resume also clears bit 7, because the operation is running again.
- R8: After a suspend command, bit 7 stays 0 until `susp_ack_i`. The acknowledge then sets bit 7 together with bit 6 (erase) or bit 2 (program).
- R9: A program started on the sector of a suspended erase ends with bit 4 set even if `op_fail_i` is 0. A program on any other sector reports the engine's flag.
- R10: Bit 5 is written only when an erase completes, and bit 4 only when a program completes. Each shows the outcome of the most recent operation of its kind.
- R11: Bit 1 holds `lock_fail_i` of the most recent completion of either kind. Bit 3 holds `wb_abort_i` of the most recent program completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset |
| op_start_i | input | 1 | Engine starts an operation |
| op_kind_i | input | 1 | 0 program, 1 erase |
| op_sector_i | input | SECT_W | Target sector of the starting operation |
| op_done_i | input | 1 | Engine finished the current operation |
| op_fail_i | input | 1 | Engine result flag, valid with op_done_i |
| wb_abort_i | input | 1 | Write-buffer abort, valid with op_done_i |
| lock_fail_i | input | 1 | Sector-locked rejection, valid with op_done_i |
| susp_ack_i | input | 1 | Engine reports that the suspend took effect |
| cmd_clear_i | input | 1 | Clear-status command |
| cmd_reset_i | input | 1 | Soft-reset command |
| cmd_erase_susp_i | input | 1 | Erase suspend command |
| cmd_erase_resume_i | input | 1 | Erase resume command |
| cmd_prog_susp_i | input | 1 | Program suspend command |
| cmd_prog_resume_i | input | 1 | Program resume command |
| status_o | output | 16 | Status word |

## Verification
The assertions assume that the engine strobes are single-cycle. They also assume that `op_done_i` and `susp_ack_i` never arrive on the same cycle as a clear command, because a completion on that cycle would legally set a flag that the clear check expects to be 0. The stimulus keeps to this: it issues every strobe alone, one cycle at a time, and drives the done, abort and lock flags only together with `op_done_i`. The sweep covers all sixteen combinations of kind, fail, abort and lock on a small sector field. It then runs the suspend and resume sequences on matching and non-matching sectors.

// File: rtl/eos_pkg.sv
package eos_pkg;
  localparam int STATUS_W = 16;
  localparam int BIT_READY = 7;
  localparam int BIT_ESUSP = 6;
  localparam int BIT_EFAIL = 5;
  localparam int BIT_PFAIL = 4;
  localparam int BIT_WBAB  = 3;
  localparam int BIT_PSUSP = 2;
  localparam int BIT_LOCK  = 1;

  localparam logic KIND_PROG  = 1'b0;
  localparam logic KIND_ERASE = 1'b1;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_ERASE = 2'd1,
    PEND_PROG  = 2'd2
  } pend_t;
endpackage

// File: rtl/eos_op_tracker.sv
module eos_op_tracker
  import eos_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst_i,
  input  logic              op_start_i,
  input  logic              op_kind_i,
  input  logic [SECT_W-1:0] op_sector_i,
  input  logic              op_done_i,
  input  logic              susp_ack_i,
  input  logic              cmd_erase_susp_i,
  input  logic              cmd_erase_resume_i,
  input  logic              cmd_prog_susp_i,
  input  logic              cmd_prog_resume_i,
  output logic              ready_o,
  output logic              esusp_o,
  output logic              psusp_o,
  output logic              done_evt_o,
  output logic              done_kind_o,
  output logic              forced_fail_o
);
  logic              ready_q, esusp_q, psusp_q, kind_q, forced_q;
  logic [SECT_W-1:0] sect_q, ssect_q;
  pend_t             pend_q;
  logic              ack_take;

  // An acknowledge only counts when a suspend request is pending.
  assign ack_take = !ready_q && susp_ack_i && (pend_q != PEND_NONE);

  always_ff @(posedge clk) begin
    if (rst || warm_rst_i) begin
      ready_q  <= 1'b1;
      esusp_q  <= 1'b0;
      psusp_q  <= 1'b0;
      kind_q   <= KIND_PROG;
      forced_q <= 1'b0;
      sect_q   <= '0;
      ssect_q  <= '0;
      pend_q   <= PEND_NONE;
    end else begin
      if (op_start_i && ready_q) begin
        ready_q  <= 1'b0;
        kind_q   <= op_kind_i;
        sect_q   <= op_sector_i;
        // A program on the sector of a suspended erase must fail.
        forced_q <= (op_kind_i == KIND_PROG) && esusp_q && (op_sector_i == ssect_q);
      end else if (ack_take) begin
        ready_q <= 1'b1;
        if (pend_q == PEND_ERASE) begin
          esusp_q <= 1'b1;
          ssect_q <= sect_q;
        end else begin
          psusp_q <= 1'b1;
        end
        pend_q <= PEND_NONE;
      end else if (!ready_q && op_done_i) begin
        ready_q <= 1'b1;
        pend_q  <= PEND_NONE;
      end else if (ready_q && cmd_erase_resume_i && esusp_q) begin
        esusp_q  <= 1'b0;
        ready_q  <= 1'b0;
        kind_q   <= KIND_ERASE;
        sect_q   <= ssect_q;
        forced_q <= 1'b0;
      end else if (ready_q && cmd_prog_resume_i && psusp_q) begin
        psusp_q <= 1'b0;
        ready_q <= 1'b0;
        kind_q  <= KIND_PROG;
      end
      if (!ready_q && pend_q == PEND_NONE && !op_done_i && !susp_ack_i) begin
        if (cmd_erase_susp_i && kind_q == KIND_ERASE) pend_q <= PEND_ERASE;
        else if (cmd_prog_susp_i && kind_q == KIND_PROG) pend_q <= PEND_PROG;
      end
    end
  end

  assign ready_o       = ready_q;
  assign esusp_o       = esusp_q;
  assign psusp_o       = psusp_q;
  assign done_evt_o    = !ready_q && op_done_i && !ack_take;
  assign done_kind_o   = kind_q;
  assign forced_fail_o = forced_q;
endmodule

// File: rtl/eos_err_flags.sv
module eos_err_flags
  import eos_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic warm_rst_i,
  input  logic done_evt_i,
  input  logic done_kind_i,
  input  logic forced_fail_i,
  input  logic op_fail_i,
  input  logic wb_abort_i,
  input  logic lock_fail_i,
  input  logic clr_i,
  output logic efail_o,
  output logic pfail_o,
  output logic wbab_o,
  output logic lock_o
);
  logic efail_q, pfail_q, wbab_q, lock_q;

  always_ff @(posedge clk) begin
    if (rst || warm_rst_i) begin
      efail_q <= 1'b0;
      pfail_q <= 1'b0;
      wbab_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      if (clr_i) begin
        efail_q <= 1'b0;
        pfail_q <= 1'b0;
        wbab_q  <= 1'b0;
        lock_q  <= 1'b0;
      end
      // A completion on the same cycle overrides the clear.
      if (done_evt_i) begin
        lock_q <= lock_fail_i;
        if (done_kind_i == KIND_PROG) begin
          pfail_q <= op_fail_i || forced_fail_i;
          wbab_q  <= wb_abort_i;
        end else begin
          efail_q <= op_fail_i;
        end
      end
    end
  end

  assign efail_o = efail_q;
  assign pfail_o = pfail_q;
  assign wbab_o  = wbab_q;
  assign lock_o  = lock_q;
endmodule

// File: rtl/eos_status_reg.sv
module eos_status_reg
  import eos_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                warm_rst_i,
  input  logic                op_start_i,
  input  logic                op_kind_i,
  input  logic [SECT_W-1:0]   op_sector_i,
  input  logic                op_done_i,
  input  logic                op_fail_i,
  input  logic                wb_abort_i,
  input  logic                lock_fail_i,
  input  logic                susp_ack_i,
  input  logic                cmd_clear_i,
  input  logic                cmd_reset_i,
  input  logic                cmd_erase_susp_i,
  input  logic                cmd_erase_resume_i,
  input  logic                cmd_prog_susp_i,
  input  logic                cmd_prog_resume_i,
  output logic [STATUS_W-1:0] status_o
);
  logic ready, esusp, psusp, done_evt, done_kind, forced;
  logic efail, pfail, wbab, lock;

  eos_op_tracker #(.SECT_W(SECT_W)) i_track (
    .clk(clk), .rst(rst), .warm_rst_i(warm_rst_i),
    .op_start_i(op_start_i), .op_kind_i(op_kind_i), .op_sector_i(op_sector_i),
    .op_done_i(op_done_i), .susp_ack_i(susp_ack_i),
    .cmd_erase_susp_i(cmd_erase_susp_i), .cmd_erase_resume_i(cmd_erase_resume_i),
    .cmd_prog_susp_i(cmd_prog_susp_i), .cmd_prog_resume_i(cmd_prog_resume_i),
    .ready_o(ready), .esusp_o(esusp), .psusp_o(psusp),
    .done_evt_o(done_evt), .done_kind_o(done_kind), .forced_fail_o(forced)
  );

  eos_err_flags i_err (
    .clk(clk), .rst(rst), .warm_rst_i(warm_rst_i),
    .done_evt_i(done_evt), .done_kind_i(done_kind), .forced_fail_i(forced),
    .op_fail_i(op_fail_i), .wb_abort_i(wb_abort_i), .lock_fail_i(lock_fail_i),
    .clr_i(cmd_clear_i || cmd_reset_i),
    .efail_o(efail), .pfail_o(pfail), .wbab_o(wbab), .lock_o(lock)
  );

  always_comb begin
    status_o            = '0;
    status_o[BIT_READY] = ready;
    // Flags are only shown while the device is ready.
    status_o[BIT_ESUSP] = ready && esusp;
    status_o[BIT_EFAIL] = ready && efail;
    status_o[BIT_PFAIL] = ready && pfail;
    status_o[BIT_WBAB]  = ready && wbab;
    status_o[BIT_PSUSP] = ready && psusp;
    status_o[BIT_LOCK]  = ready && lock;
  end
endmodule

// File: rtl/eos_status_chk.sv
module eos_status_chk (
  input logic        clk,
  input logic        rst,
  input logic        warm_rst_i,
  input logic        op_start_i,
  input logic        op_done_i,
  input logic        susp_ack_i,
  input logic        cmd_clear_i,
  input logic        cmd_reset_i,
  input logic        cmd_erase_resume_i,
  input logic [15:0] status_o
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status_o[15:8] == 8'h00) && !status_o[0]); // R2
  AST_BUSY_MASK: assert property (@(posedge clk) disable iff (rst)
    !status_o[7] |-> (status_o[6:1] == 6'b0)); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (op_start_i && status_o[7] && !warm_rst_i) |=> !status_o[7]); // R4
  AST_WARM_IDLE: assert property (@(posedge clk) disable iff (rst)
    warm_rst_i |=> (status_o == 16'h0080)); // R5
  AST_CLEAR_ERR: assert property (@(posedge clk) disable iff (rst)
    ((cmd_clear_i || cmd_reset_i) && !op_done_i && !susp_ack_i)
      |=> (status_o[5:3] == 3'b0) && !status_o[1]); // R6
  AST_ERESUME: assert property (@(posedge clk) disable iff (rst)
    cmd_erase_resume_i |=> !status_o[6]); // R7
  AST_SUSP_WAIT: assert property (@(posedge clk) disable iff (rst)
    (!status_o[7] && !susp_ack_i && !op_done_i && !warm_rst_i) |=> !status_o[7]); // R8
endmodule

bind eos_status_reg eos_status_chk i_chk (
  .clk(clk), .rst(rst), .warm_rst_i(warm_rst_i), .op_start_i(op_start_i),
  .op_done_i(op_done_i), .susp_ack_i(susp_ack_i), .cmd_clear_i(cmd_clear_i),
  .cmd_reset_i(cmd_reset_i), .cmd_erase_resume_i(cmd_erase_resume_i),
  .status_o(status_o)
);

// File: tb/test_eos_status_reg.sv
`timescale 1ns/1ps
module test_eos_status_reg;
  localparam int SW = 3;
  logic clk = 1'b0;
  logic rst, warm, start, kind, done, fail, wab, lck, ack;
  logic cclr, crst, esus, eres, psus, pres;
  logic [SW-1:0] sect;
  logic [15:0] status;
  int checks = 0, failures = 0;
  bit finished = 0;
  logic m_e, m_p, m_w, m_l;

  always #10 clk = ~clk;

  eos_status_reg #(.SECT_W(SW)) i_eos_status_reg (
    .clk(clk), .rst(rst), .warm_rst_i(warm), .op_start_i(start), .op_kind_i(kind),
    .op_sector_i(sect), .op_done_i(done), .op_fail_i(fail), .wb_abort_i(wab),
    .lock_fail_i(lck), .susp_ack_i(ack), .cmd_clear_i(cclr), .cmd_reset_i(crst),
    .cmd_erase_susp_i(esus), .cmd_erase_resume_i(eres), .cmd_prog_susp_i(psus),
    .cmd_prog_resume_i(pres), .status_o(status)
  );

  task automatic chk(input string req, input logic [15:0] exp);
    checks++;
    if (status !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, status, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    start = 0; done = 0; fail = 0; wab = 0; lck = 0; ack = 0; warm = 0;
    cclr = 0; crst = 0; esus = 0; eres = 0; psus = 0; pres = 0;
  endtask

  function automatic logic [15:0] ready_word(logic es, logic ps);
    return 16'h0080 | (16'(es) << 6) | (16'(m_e) << 5) | (16'(m_p) << 4)
         | (16'(m_w) << 3) | (16'(ps) << 2) | (16'(m_l) << 1);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; sect = '0; kind = 0;
    start = 0; done = 0; fail = 0; wab = 0; lck = 0; ack = 0; warm = 0;
    cclr = 0; crst = 0; esus = 0; eres = 0; psus = 0; pres = 0;
    m_e = 0; m_p = 0; m_w = 0; m_l = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    chk("R1 R2 reset word", 16'h0080);

    // Sweep kind x fail x abort x lock; model follows R10/R11.
    for (int v = 0; v < 16; v++) begin
      kind = v[0]; sect = SW'(v); start = 1;
      tick();
      chk("R4 R3 busy after start", 16'h0000);
      done = 1; fail = v[1]; wab = v[2]; lck = v[3];
      if (!v[0]) begin m_p = v[1]; m_w = v[2]; end else m_e = v[1];
      m_l = v[3];
      tick();
      chk("R4 R10 R11 completion word", ready_word(0, 0));
    end
    done = 1; fail = 1; lck = 1;
    tick();
    chk("R4 done while ready ignored", ready_word(0, 0));

    // Clear and soft reset.
    m_e = 1; m_p = 1; m_w = 1; m_l = 1;
    kind = 0; start = 1; tick(); done = 1; fail = 1; wab = 1; lck = 1; tick();
    kind = 1; start = 1; tick(); done = 1; fail = 1; lck = 1; tick();
    chk("R10 R11 all errors", ready_word(0, 0));
    cclr = 1; tick();
    m_e = 0; m_p = 0; m_w = 0; m_l = 0;
    chk("R6 clear status", 16'h0080);
    kind = 0; start = 1; tick(); done = 1; fail = 1; tick();
    crst = 1; tick();
    chk("R6 reset command", 16'h0080);

    // Erase suspend on sector 3.
    kind = 1; sect = 3; start = 1; tick();
    esus = 1; tick();
    tick(); tick();
    chk("R8 ready held low until ack", 16'h0000);
    ack = 1; tick();
    chk("R8 erase suspended", 16'h00C0);
    kind = 0; sect = 3; start = 1; tick();
    done = 1; fail = 0; tick();
    m_p = 1;
    chk("R9 program on suspended sector fails", ready_word(1, 0));
    cclr = 1; tick();
    m_p = 0;
    chk("R6 clear keeps suspend bit", 16'h00C0);
    kind = 0; sect = 5; start = 1; tick();
    done = 1; tick();
    chk("R9 other sector passes", 16'h00C0);
    eres = 1; tick();
    chk("R7 erase resume", 16'h0000);
    done = 1; tick();
    chk("R7 resumed erase completes", 16'h0080);

    // Program suspend.
    kind = 0; sect = 1; start = 1; tick();
    psus = 1; tick();
    chk("R8 program suspend pending", 16'h0000);
    ack = 1; tick();
    chk("R8 program suspended", 16'h0084);
    pres = 1; tick();
    chk("R7 program resume", 16'h0000);
    done = 1; tick();
    chk("R7 resumed program completes", 16'h0080);

    // Warm reset from an error and suspend state.
    kind = 1; start = 1; tick(); done = 1; fail = 1; lck = 1; tick();
    kind = 1; start = 1; tick(); esus = 1; tick(); ack = 1; tick();
    chk("R8 suspend with errors", 16'h00E2);
    warm = 1; tick();
    chk("R5 warm reset", 16'h0080);
    finish_run();
  end
endmodule